// File: doc/BRIEF.md
# GPIO Bank Register File with Mask-Selected Pin Configuration

This block holds the control state for one bank of general-purpose pins and exposes it to a host through a single-cycle memory-mapped read/write port. Each pin owns a configuration word holding its function selection, direction, bias, drive and input-conditioning settings. The block drives these settings out as per-pin control vectors toward the pad ring.

Configuration is reached indirectly. The host first loads a pin-select mask. One configuration address then serves every pin. A write to that address lands in every selected pin at once, and a read returns the word of the lowest selected pin. Output levels change only through a write-ones-to-set address and a write-ones-to-clear address, so one pin can be driven without a read-modify-write. The host can read back the output levels and the synchronized pad levels.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every configuration word, the mask and every output level are zero. This means function 0 (plain GPIO), input direction, no pulls, and all control outputs low.
- R2: A write to offset 0x00 loads the pin-select mask (bit n selects pin n). A read of 0x00 returns the mask.
- R3: A write to offset 0x04 stores write-data into the configuration word of every pin whose mask bit is set and leaves the other pins unchanged. Only bits 2:0, 8, 9, 10, 12, 13, 14, 15 and 26:24 are stored. All other bits read back as zero.
- R4: A read of offset 0x04 returns the configuration word of the lowest-numbered pin selected in the mask. It returns zero when the mask is zero.
- R5: Configuration fields drive the per-pin outputs as follows: bits 2:0 to func_sel, bit 8 to dir_out (1 = output), bit 9 to pull_up, bit 10 to pull_dn, bit 12 to filt_en, bit 13 to filt_slow, bit 14 to open_drain and bit 15 to schmitt. Bits 26:24 hold an event-select code that can only be read back.
- R6: A write to offset 0x10 sets each output level whose write-data bit is 1. Bits written as 0 leave their outputs unchanged.
- R7: A write to offset 0x14 clears each output level whose write-data bit is 1. Bits written as 0 leave their outputs unchanged.
- R8: A read of offset 0x18 returns the current output levels.
- R9: A read of offset 0x08 returns pad_in after a two-flop synchronizer. A pad value present at clock edge k becomes readable after edge k+1.
- R10: Writes to offsets 0x08, 0x0C, 0x18 and to unmapped offsets change no state. Reads of 0x0C and of unmapped offsets return zero.
- R11: Read data is combinational and valid in the same cycle as the request. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pad_in | input | NPIN | Asynchronous pad levels |
| out_level | output | NPIN | Output data levels |
| dir_out | output | NPIN | Per-pin output enable |
| func_sel | output | 3*NPIN | Per-pin function code, pin n at bits 3n+2:3n |
| pull_up | output | NPIN | Pull-up enable |
| pull_dn | output | NPIN | Pull-down enable |
| open_drain | output | NPIN | Open-drain drive |
| schmitt | output | NPIN | Schmitt-trigger control |
| filt_en | output | NPIN | Input filter enable |
| filt_slow | output | NPIN | Filter slow-clock enable |

## Verification
The hardest situation to reach is a configuration read under a mask that selects several pins holding different words. The lowest-pin priority is only visible when those words differ. The stimulus therefore first gives a handful of pins distinct words through one-hot masks. It then reads back under overlapping multi-bit masks, including masks whose lowest bit is high in the bank, and under an empty mask. A long pseudo-random stretch then mixes mask, configuration, set/clear, read-only and unmapped accesses while the pads toggle. A behavioural model checks every output and every read on each cycle.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   out_level,
  output logic [NPIN-1:0]   dir_out,
  output logic [3*NPIN-1:0] func_sel,
  output logic [NPIN-1:0]   pull_up,
  output logic [NPIN-1:0]   pull_dn,
  output logic [NPIN-1:0]   open_drain,
  output logic [NPIN-1:0]   schmitt,
  output logic [NPIN-1:0]   filt_en,
  output logic [NPIN-1:0]   filt_slow
);
  localparam int          DW       = 32;
  localparam logic [DW-1:0] CFG_KEEP = 32'h0700_F707;
  localparam logic [AW-1:0] A_MASK = AW'('h00);
  localparam logic [AW-1:0] A_CFG  = AW'('h04);
  localparam logic [AW-1:0] A_PDS  = AW'('h08);
  localparam logic [AW-1:0] A_SET  = AW'('h10);
  localparam logic [AW-1:0] A_CLR  = AW'('h14);
  localparam logic [AW-1:0] A_ODS  = AW'('h18);

  logic [NPIN-1:0] mask_q, out_q, sync_a, sync_b;
  logic [DW-1:0]   cfg_q [NPIN];
  logic [DW-1:0]   cfg_pick;

  wire wr_en  = bus_sel & bus_wr;
  wire wr_cfg = wr_en & (bus_addr == A_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      out_q  <= '0;
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pad_in;
      sync_b <= sync_a;
      if (wr_en && bus_addr == A_MASK) mask_q <= bus_wdata[NPIN-1:0];
      if (wr_en && bus_addr == A_SET)  out_q  <= out_q | bus_wdata[NPIN-1:0];
      if (wr_en && bus_addr == A_CLR)  out_q  <= out_q & ~bus_wdata[NPIN-1:0];
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)                  cfg_q[g] <= '0;
      else if (wr_cfg && mask_q[g]) cfg_q[g] <= bus_wdata & CFG_KEEP;
    end
    assign func_sel[3*g +: 3] = cfg_q[g][2:0];
    assign dir_out[g]         = cfg_q[g][8];
    assign pull_up[g]         = cfg_q[g][9];
    assign pull_dn[g]         = cfg_q[g][10];
    assign filt_en[g]         = cfg_q[g][12];
    assign filt_slow[g]       = cfg_q[g][13];
    assign open_drain[g]      = cfg_q[g][14];
    assign schmitt[g]         = cfg_q[g][15];

    // R3: an unselected pin keeps its word across a configuration write
    p_unsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && !mask_q[g]) |=> $stable(cfg_q[g]));
  end

  always_comb begin
    cfg_pick = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (mask_q[i]) cfg_pick = cfg_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_MASK:  bus_rdata = DW'(mask_q);
        A_CFG:   bus_rdata = cfg_pick;
        A_PDS:   bus_rdata = DW'(sync_b);
        A_ODS:   bus_rdata = DW'(out_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign out_level = out_q;

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_SET) |=>
      ((out_level & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_CLR) |=> ((out_level & $past(bus_wdata[NPIN-1:0])) == '0));

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (bus_addr == A_SET || bus_addr == A_CLR))) |=> $stable(out_level));

  p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == A_CFG && mask_q == '0) |-> (bus_rdata == '0));

  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> ($stable(dir_out) && $stable(func_sel) && $stable(pull_up) && $stable(pull_dn)));
endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] pad_in = 0, out_level, dir_out, pull_up, pull_dn, open_drain, schmitt, filt_en, filt_slow;
  logic [95:0] func_sel;

  gpio_bank_regs u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .out_level(out_level), .dir_out(dir_out), .func_sel(func_sel), .pull_up(pull_up),
    .pull_dn(pull_dn), .open_drain(open_drain), .schmitt(schmitt), .filt_en(filt_en),
    .filt_slow(filt_slow));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_cfg [32];
  logic [31:0] m_mask, m_out;
  logic [31:0] pad_hist [$];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = 0;
    case (a)
      8'h00: r = m_mask;
      8'h04: for (int i = 31; i >= 0; i--) if (m_mask[i]) r = m_cfg[i];
      8'h08: r = (pad_hist.size() >= 2) ? pad_hist[pad_hist.size()-2] : 32'h0;
      8'h18: r = m_out;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic chk_outputs();
    logic [31:0] e_dir, e_pu, e_pd, e_fe, e_fs, e_od, e_st;
    logic [95:0] e_fn;
    for (int i = 0; i < 32; i++) begin
      e_fn[3*i +: 3] = m_cfg[i][2:0];
      e_dir[i] = m_cfg[i][8];  e_pu[i] = m_cfg[i][9];  e_pd[i] = m_cfg[i][10];
      e_fe[i]  = m_cfg[i][12]; e_fs[i] = m_cfg[i][13]; e_od[i] = m_cfg[i][14];
      e_st[i]  = m_cfg[i][15];
    end
    chk("R5 func_sel", func_sel, e_fn);
    chk("R5 dir_out", dir_out, e_dir);
    chk("R5 pull_up", pull_up, e_pu);
    chk("R5 pull_dn", pull_dn, e_pd);
    chk("R5 filt_en", filt_en, e_fe);
    chk("R5 filt_slow", filt_slow, e_fs);
    chk("R5 open_drain", open_drain, e_od);
    chk("R5 schmitt", schmitt, e_st);
    chk("R6/R7 out_level", out_level, m_out);
  endtask

  task automatic step(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] p, input string tag);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; pad_in = p;
    #1;
    chk_outputs();
    // R11: read data is checked in the request cycle
    if (s && !w) chk({tag, " rdata"}, bus_rdata, exp_read(a));
    else         chk("R11 idle rdata", bus_rdata, 32'h0);
    @(posedge clk);
    pad_hist.push_back(p);
    if (s && w) begin
      case (a)
        8'h00: m_mask = d;
        8'h04: for (int i = 0; i < 32; i++) if (m_mask[i]) m_cfg[i] = d & 32'h0700_F707;
        8'h10: m_out = m_out | d;
        8'h14: m_out = m_out & ~d;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, pad_in, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 0, pad_in, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_cfg[i] = 0;
    m_mask = 0; m_out = 0;
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h04;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during and right after reset
    chk_outputs();
    chk("R1 cfg read in reset", bus_rdata, 32'h0);
    rst_n = 1;
    pad_hist.delete();
    rd(8'h00, "R1 mask");
    rd(8'h18, "R1 outputs");

    // R2 / R3 / R5: give distinct words to pins 3, 7, 20, 31
    wr(8'h00, 32'h0000_0008, "R2");  rd(8'h00, "R2 mask readback");
    wr(8'h04, 32'hFFFF_FFFF, "R3");  rd(8'h04, "R3 reserved bits zero");
    wr(8'h00, 32'h0000_0080, "R2");  wr(8'h04, 32'h0200_0301, "R3");
    wr(8'h00, 32'h0010_0000, "R2");  wr(8'h04, 32'h0400_D402, "R5");
    wr(8'h00, 32'h8000_0000, "R2");  wr(8'h04, 32'h0100_2105, "R5");
    rd(8'h04, "R4 single pin 31");
    // R4: lowest selected pin wins
    wr(8'h00, 32'h8010_0080, "R2");  rd(8'h04, "R4 lowest of 7,20,31");
    wr(8'h00, 32'h8010_0000, "R2");  rd(8'h04, "R4 lowest of 20,31");
    wr(8'h00, 32'h8000_0001, "R2");  rd(8'h04, "R4 lowest pin 0");
    wr(8'h00, 32'h0000_0000, "R2");  rd(8'h04, "R4 empty mask");
    // R3: broadcast to several pins, others untouched
    wr(8'h00, 32'h0000_0600, "R2");  wr(8'h04, 32'h0000_8106, "R3 broadcast");
    wr(8'h00, 32'h0000_0400, "R2");  rd(8'h04, "R3 pin 10");
    wr(8'h00, 32'h0000_0080, "R2");  rd(8'h04, "R3 pin 7 untouched");
    // R6 / R7 / R8
    wr(8'h10, 32'hA5A5_0F0F, "R6");  rd(8'h18, "R8 after set");
    wr(8'h10, 32'h0000_0000, "R6 zero set");  rd(8'h18, "R6 zero set no change");
    wr(8'h14, 32'h0505_0101, "R7");  rd(8'h18, "R7 after clear");
    wr(8'h14, 32'h0000_0000, "R7 zero clear"); rd(8'h18, "R7 zero clear no change");
    // R10: read-only and unmapped writes ignored; reads of them return zero
    wr(8'h08, 32'hFFFF_FFFF, "R10"); wr(8'h0C, 32'hFFFF_FFFF, "R10");
    wr(8'h18, 32'h0000_0000, "R10"); wr(8'h3C, 32'hFFFF_FFFF, "R10");
    rd(8'h18, "R10 outputs kept"); rd(8'h04, "R10 cfg kept");
    rd(8'h0C, "R10 lock reads zero"); rd(8'h20, "R10 unmapped zero");
    // R9: synchronizer latency
    step(0, 0, 0, 0, 32'h1234_5678, "R9");
    step(1, 0, 8'h08, 0, 32'h1234_5678, "R9 one edge");
    step(1, 0, 8'h08, 0, 32'hCAFE_0001, "R9 two edges");
    step(1, 0, 8'h08, 0, 32'hCAFE_0001, "R9 change pending");
    step(1, 0, 8'h08, 0, 32'h0, "R9 settled");
    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom_range(0, 8))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; 7: a = 8'h24; default: a = 8'h04;
      endcase
      d = $urandom();
      if (a == 8'h00 && d[0]) d = d & (32'h1 << $urandom_range(0, 31));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d, $urandom(), "R3/R4/R9 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule